// File: doc/BRIEF.md
# Port-Mapped Command Watchdog Controller

This block is the device side of a hardware watchdog that a host reaches through two byte-wide I/O ports. One port takes single-byte commands and the other carries data. The commands probe for the device, start, stop and reload the watchdog, and open an indirect register write. Software sees the device as a probe-able peripheral and configures it with short byte sequences.

Two 16-bit delays set the timing, an enable delay and a reset delay. Both count in 100 ms ticks, and a parameterised prescaler derives the tick from the core clock. On start, the block waits out the enable delay and then counts down the reset delay. If the host does not reload in time, the countdown expires and the block drives a reset pulse of parameterised length. After the pulse it returns to the stopped state.

Delay registers are written indirectly. The host sends a command byte, then a register index on the data port, then the value on the data port. A probe command arms a one-shot signature that the next data-port read returns.

Top module: `io_cmd_watchdog`

## Requirements
- R1: After reset `wdtReset` is low, `hostRdata` is 0x00, both delays are zero and the watchdog is stopped.
- R2: Writing command 0x30 to the command port (address 1) makes the next data-port read (address 0) return 0x95. That read consumes it. Any other command write in between cancels it. Every other data-port read returns 0x00.
- R3: Command 0x89 followed by two data-port writes (index, then value) loads a delay byte. Index 0x58 is the enable-delay high byte, 0x59 the enable-delay low byte, 0x5E the reset-delay high byte and 0x5F the reset-delay low byte. Other indices change nothing. All 16 bits of each delay take effect.
- R4: A command-port write in the middle of an indirect sequence aborts it, and the command byte is then acted on as usual. Data-port writes that are outside a sequence are ignored.
- R5: Command 0x28 written at clock edge E0 starts the watchdog. With enable delay E and reset delay D, `wdtReset` first rises at edge E0 + (E + max(D,1)) × TICK_CLKS. E = 0 means no enable wait.
- R6: Command 0x2A written at edge Er while the reset delay is counting down restarts that countdown, so expiry moves to Er + max(D,1) × TICK_CLKS. It is ignored while stopped or during the enable wait.
- R7: Command 0x29 before expiry stops the watchdog with no reset. A later start behaves as in R5.
- R8: On expiry `wdtReset` stays high for exactly RST_PULSE_CLKS cycles. The watchdog is then stopped and gives no further pulse until it is started again.
- R9: Command bytes other than 0x28, 0x29, 0x2A, 0x30 and 0x89 have no effect on a running countdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Host write strobe, one cycle per access |
| hostRd | input | 1 | Host read strobe, one cycle per access |
| hostAddr | input | 1 | Port select: 0 data port, 1 command port |
| hostWdata | input | 8 | Byte written by the host |
| hostRdata | output | 8 | Byte returned on a data-port read |
| wdtReset | output | 1 | Reset pulse on watchdog expiry |

## Verification
The bench builds the block with TICK_CLKS = 4 and RST_PULSE_CLKS = 3, so one tick lasts four cycles and expiry edges follow from a simple product. This makes a complete sweep feasible: every enable delay from 0 to 3 against every reset delay from 0 to 5, including the zero cases. Delays above 255 ticks, which need both high bytes, also run in about a thousand cycles. Timing runs and port-level observation of expiry cover reload, stop, abort, unknown commands and the one-shot signature.

// File: rtl/io_cmd_wdt_pkg.sv
package io_cmd_wdt_pkg;

  localparam int DLY_W = 16;

  localparam logic [7:0] CMD_START    = 8'h28;
  localparam logic [7:0] CMD_STOP     = 8'h29;
  localparam logic [7:0] CMD_RELOAD   = 8'h2A;
  localparam logic [7:0] CMD_PROBE    = 8'h30;
  localparam logic [7:0] CMD_INDIRECT = 8'h89;
  localparam logic [7:0] PROBE_SIG    = 8'h95;

  // delay byte slots: 0 enable hi, 1 enable lo, 2 reset hi, 3 reset lo
  localparam int NUM_DLY_BYTES = 4;
  localparam logic [7:0] REG_IDX [NUM_DLY_BYTES] = '{8'h58, 8'h59, 8'h5E, 8'h5F};

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_INDEX,
    SEQ_VALUE
  } seqState_e;

  typedef enum logic [1:0] {
    RUN_IDLE,
    RUN_ARM,
    RUN_COUNT,
    RUN_FIRE
  } runState_e;

  typedef struct packed {
    logic       start;
    logic       stop;
    logic       reload;
    logic       regWr;
    logic [7:0] regIdx;
    logic [7:0] regVal;
  } wdtStrobes_t;

endpackage

// File: rtl/io_cmd_wdt_ctrl.sv
module io_cmd_wdt_ctrl
  import io_cmd_wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWr,
  input  logic        hostRd,
  input  logic        hostAddr,
  input  logic [7:0]  hostWdata,
  output logic [7:0]  hostRdata,
  output wdtStrobes_t stb
);

  logic      cmdWr;
  logic      datWr;
  logic      datRd;
  seqState_e seqState;
  logic [7:0] idxQ;
  logic      probePending;

  always_comb begin
    cmdWr = hostWr && hostAddr;
    datWr = hostWr && !hostAddr;
    datRd = hostRd && !hostAddr;
  end

  // command decode into one-cycle strobes
  always_comb begin
    stb        = '0;
    stb.start  = cmdWr && (hostWdata == CMD_START);
    stb.stop   = cmdWr && (hostWdata == CMD_STOP);
    stb.reload = cmdWr && (hostWdata == CMD_RELOAD);
    stb.regWr  = datWr && (seqState == SEQ_VALUE);
    stb.regIdx = idxQ;
    stb.regVal = hostWdata;
  end

  // indirect write sequencer: command, index, value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqState <= SEQ_IDLE;
      idxQ     <= '0;
    end else if (cmdWr) begin
      seqState <= (hostWdata == CMD_INDIRECT) ? SEQ_INDEX : SEQ_IDLE;
    end else if (datWr) begin
      case (seqState)
        SEQ_INDEX: begin
          idxQ     <= hostWdata;
          seqState <= SEQ_VALUE;
        end
        SEQ_VALUE: seqState <= SEQ_IDLE;
        default:   seqState <= SEQ_IDLE;
      endcase
    end
  end

  // one-shot signature
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      probePending <= 1'b0;
    end else if (cmdWr) begin
      probePending <= (hostWdata == CMD_PROBE);
    end else if (datRd) begin
      probePending <= 1'b0;
    end
  end

  assign hostRdata = (datRd && probePending) ? PROBE_SIG : 8'h00;

  // R4
  seq_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr) |=> (seqState != SEQ_VALUE));

  // R2
  probe_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !hostAddr && !hostWr) |=> !probePending);

  // R2
  rd_sig_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdata != 8'h00) |-> (hostRdata == PROBE_SIG && hostRd && !hostAddr));

endmodule

// File: rtl/io_cmd_wdt_dp.sv
module io_cmd_wdt_dp
  import io_cmd_wdt_pkg::*;
#(
  parameter int TICK_CLKS      = 20_000_000,
  parameter int RST_PULSE_CLKS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  wdtStrobes_t stb,
  output logic        wdtReset
);

  localparam int PRE_W = $clog2(TICK_CLKS + 1);
  localparam int PC_W  = $clog2(RST_PULSE_CLKS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST   = PRE_W'(TICK_CLKS - 1);
  localparam logic [PC_W-1:0]  PULSE_LAST = PC_W'(RST_PULSE_CLKS - 1);

  logic [NUM_DLY_BYTES-1:0][7:0] dlyBytes;
  logic [DLY_W-1:0] enDly;
  logic [DLY_W-1:0] rstDly;

  // delay byte registers, one per index
  for (genvar g = 0; g < NUM_DLY_BYTES; g++) begin : g_dly
    logic [7:0] byteQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        byteQ <= '0;
      end else if (stb.regWr && (stb.regIdx == REG_IDX[g])) begin
        byteQ <= stb.regVal;
      end
    end
    assign dlyBytes[g] = byteQ;
  end

  assign enDly  = {dlyBytes[0], dlyBytes[1]};
  assign rstDly = {dlyBytes[2], dlyBytes[3]};

  runState_e        runState;
  logic [DLY_W-1:0] cnt;
  logic [PRE_W-1:0] preCnt;
  logic [PC_W-1:0]  pulseCnt;
  logic             tick;
  logic             lastTick;

  assign tick     = (preCnt == PRE_LAST);
  assign lastTick = tick && (cnt <= DLY_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runState <= RUN_IDLE;
      cnt      <= '0;
      preCnt   <= '0;
      pulseCnt <= '0;
    end else begin
      case (runState)
        RUN_IDLE: begin
          if (stb.start) begin
            preCnt <= '0;
            if (enDly != '0) begin
              runState <= RUN_ARM;
              cnt      <= enDly;
            end else begin
              runState <= RUN_COUNT;
              cnt      <= rstDly;
            end
          end
        end
        RUN_ARM, RUN_COUNT: begin
          if (stb.stop) begin
            runState <= RUN_IDLE;
            preCnt   <= '0;
          end else if (stb.start) begin
            preCnt <= '0;
            if (enDly != '0) begin
              runState <= RUN_ARM;
              cnt      <= enDly;
            end else begin
              runState <= RUN_COUNT;
              cnt      <= rstDly;
            end
          end else if (stb.reload && runState == RUN_COUNT) begin
            cnt    <= rstDly;
            preCnt <= '0;
          end else begin
            preCnt <= tick ? '0 : preCnt + 1'b1;
            if (lastTick) begin
              if (runState == RUN_ARM) begin
                runState <= RUN_COUNT;
                cnt      <= rstDly;
              end else begin
                runState <= RUN_FIRE;
                pulseCnt <= PULSE_LAST;
              end
            end else if (tick) begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        RUN_FIRE: begin
          preCnt <= '0;
          if (pulseCnt == '0) begin
            runState <= RUN_IDLE;
          end else begin
            pulseCnt <= pulseCnt - 1'b1;
          end
        end
        default: runState <= RUN_IDLE;
      endcase
    end
  end

  assign wdtReset = (runState == RUN_FIRE);

  // checker: length of the current high phase of the reset output
  logic [PC_W:0] hiLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiLen <= '0;
    end else if (wdtReset) begin
      hiLen <= hiLen + 1'b1;
    end else begin
      hiLen <= '0;
    end
  end

  // R5
  pre_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    preCnt < PRE_W'(TICK_CLKS));

  // R7
  stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stop && (runState == RUN_ARM || runState == RUN_COUNT)) |=> !wdtReset && runState == RUN_IDLE);

  // R8
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdtReset |-> (hiLen < (PC_W+1)'(RST_PULSE_CLKS)));

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.reload && runState == RUN_COUNT) |=> (cnt == $past(rstDly)));

endmodule

// File: rtl/io_cmd_watchdog.sv
module io_cmd_watchdog
  import io_cmd_wdt_pkg::*;
#(
  parameter int TICK_CLKS      = 20_000_000,
  parameter int RST_PULSE_CLKS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic       hostAddr,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  output logic       wdtReset
);

  wdtStrobes_t stb;

  io_cmd_wdt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostWr    (hostWr),
    .hostRd    (hostRd),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .stb       (stb)
  );

  io_cmd_wdt_dp #(
    .TICK_CLKS      (TICK_CLKS),
    .RST_PULSE_CLKS (RST_PULSE_CLKS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wdtReset (wdtReset)
  );

endmodule

// File: tb/io_cmd_watchdog_bench.sv
`timescale 1ns/1ps
module io_cmd_watchdog_bench;

  localparam int T = 4;
  localparam int P = 3;
  localparam logic [7:0] C_START  = 8'h28;
  localparam logic [7:0] C_STOP   = 8'h29;
  localparam logic [7:0] C_RELOAD = 8'h2A;
  localparam logic [7:0] C_PROBE  = 8'h30;
  localparam logic [7:0] C_IND    = 8'h89;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWr = 1'b0;
  logic       hostRd = 1'b0;
  logic       hostAddr = 1'b0;
  logic [7:0] hostWdata = 8'h00;
  logic [7:0] hostRdata;
  logic       wdtReset;

  int cyc = 0;
  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  io_cmd_watchdog #(.TICK_CLKS(T), .RST_PULSE_CLKS(P)) u_io_cmd_watchdog (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .wdtReset(wdtReset)
  );

  task automatic chkEq(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // one write access; edgeNo is the clock edge that samples it
  task automatic hostWrite(input logic a, input logic [7:0] d, output int edgeNo);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    edgeNo = cyc + 1;
    @(negedge clk);
    hostWr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    int e;
    hostWrite(a, d, e);
  endtask

  task automatic hostRead(output logic [7:0] d);
    @(negedge clk);
    hostAddr = 1'b0; hostRd = 1'b1;
    #1 d = hostRdata;
    @(negedge clk);
    hostRd = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic setReg(input logic [7:0] idx, input logic [7:0] val);
    wr(1'b1, C_IND);
    wr(1'b0, idx);
    wr(1'b0, val);
  endtask

  task automatic setDelays(input logic [15:0] en, input logic [15:0] rs);
    setReg(8'h58, en[15:8]);
    setReg(8'h59, en[7:0]);
    setReg(8'h5E, rs[15:8]);
    setReg(8'h5F, rs[7:0]);
  endtask

  task automatic expectQuiet(input int n, input string req);
    bit seen;
    seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (wdtReset) seen = 1'b1;
    end
    chkEq(req, int'(seen), 0);
  endtask

  // wait for expiry, check its edge, the pulse width and the quiet after
  task automatic expectFire(input int expEdge, input string req);
    int n;
    int lim;
    int w;
    n = 0;
    lim = expEdge - cyc + 40;
    while (!wdtReset && n < lim) begin
      @(negedge clk);
      n++;
    end
    chkEq(req, wdtReset ? cyc : -1, expEdge);
    w = 0;
    while (wdtReset && w < 100) begin
      w++;
      @(negedge clk);
    end
    chkEq("R8 width", w, P);
    expectQuiet(4 * T, "R8 stopped");
  endtask

  function automatic int dEff(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int e0;
    int er;
    logic [7:0] rd;

    repeat (3) @(negedge clk);
    // R1 reset state
    chkEq("R1 reset out", int'(wdtReset), 0);
    chkEq("R1 rdata", int'(hostRdata), 0);
    rstN = 1'b1;
    // R1: start with zero delays fires after one tick
    hostWrite(1'b1, C_START, e0);
    expectFire(e0 + T, "R1 zero delays");

    // R2 probe signature
    hostRead(rd);
    chkEq("R2 no probe", int'(rd), 0);
    wr(1'b1, C_PROBE);
    hostRead(rd);
    chkEq("R2 signature", int'(rd), 8'h95);
    hostRead(rd);
    chkEq("R2 consumed", int'(rd), 0);
    wr(1'b1, C_PROBE);
    wr(1'b1, 8'h55);
    hostRead(rd);
    chkEq("R2 cancelled", int'(rd), 0);

    // R5 sweep of enable and reset delays
    for (int en = 0; en < 4; en++) begin
      for (int rs = 0; rs < 6; rs++) begin
        setDelays(16'(en), 16'(rs));
        hostWrite(1'b1, C_START, e0);
        expectFire(e0 + (en + dEff(rs)) * T, "R5 sweep");
      end
    end

    // R3 high bytes of both delays
    setDelays(16'h0000, 16'h0102);
    hostWrite(1'b1, C_START, e0);
    expectFire(e0 + 258 * T, "R3 reset hi byte");
    setDelays(16'h0101, 16'h0003);
    hostWrite(1'b1, C_START, e0);
    expectFire(e0 + 260 * T, "R3 enable hi byte");

    // R3 unknown index changes nothing; R4 abort and stray data
    setDelays(16'h0000, 16'h0004);
    setReg(8'h10, 8'h07);
    setReg(8'h5A, 8'h09);
    wr(1'b1, C_IND);
    wr(1'b0, 8'h5F);
    wr(1'b1, 8'h77);
    wr(1'b0, 8'h09);
    wr(1'b0, 8'h5F);
    wr(1'b0, 8'h01);
    hostWrite(1'b1, C_START, e0);
    expectFire(e0 + 4 * T, "R4 abort keeps delay");
    wr(1'b1, C_IND);
    wr(1'b0, 8'h5E);
    wr(1'b1, C_IND);
    wr(1'b0, 8'h5F);
    wr(1'b0, 8'h02);
    hostWrite(1'b1, C_START, e0);
    expectFire(e0 + 2 * T, "R4 restart sequence");

    // R9 unknown commands while counting
    setDelays(16'h0000, 16'h0006);
    hostWrite(1'b1, C_START, e0);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'hFF);
    wr(1'b1, 8'h2B);
    wr(1'b1, 8'h31);
    expectFire(e0 + 6 * T, "R9 unknown ignored");

    // R6 reload during countdown
    hostWrite(1'b1, C_START, e0);
    repeat (10) @(negedge clk);
    hostWrite(1'b1, C_RELOAD, er);
    expectFire(er + 6 * T, "R6 reload");
    // R6 reload twice
    hostWrite(1'b1, C_START, e0);
    repeat (12) @(negedge clk);
    hostWrite(1'b1, C_RELOAD, er);
    repeat (8) @(negedge clk);
    hostWrite(1'b1, C_RELOAD, er);
    expectFire(er + 6 * T, "R6 second reload");
    // R6 reload while stopped does nothing
    wr(1'b1, C_RELOAD);
    expectQuiet(10 * T, "R6 reload idle");
    // R6 reload during enable wait ignored
    setDelays(16'h0003, 16'h0002);
    hostWrite(1'b1, C_START, e0);
    wr(1'b1, C_RELOAD);
    expectFire(e0 + 5 * T, "R6 reload in enable wait");

    // R7 stop before expiry, then restart
    setDelays(16'h0000, 16'h0005);
    hostWrite(1'b1, C_START, e0);
    repeat (8) @(negedge clk);
    wr(1'b1, C_STOP);
    expectQuiet(10 * T, "R7 stopped");
    hostWrite(1'b1, C_START, e0);
    expectFire(e0 + 5 * T, "R7 restart");
    // R7 stop during enable wait
    setDelays(16'h0002, 16'h0001);
    hostWrite(1'b1, C_START, e0);
    wr(1'b1, C_STOP);
    expectQuiet(10 * T, "R7 stop in enable wait");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule